// File: doc/BRIEF.md
# Daisy-chain DAC loader

This block sits on the host side of a chain of serial-input 16-bit digital-to-analog converters. All converters share one serial clock and one update strobe. The serial output of each device feeds the serial input of the next. The block takes one word per converter through a valid/ready port. Once all of them are held, it shifts the whole chain in a single burst with the shift enable held low. It then strobes the shared update enable once, so that every converter changes its output at the same moment. On request it also drives the active-low clear line of the chain.

The serial clock is derived from the system clock. Each high phase and each low phase lasts `HALF_CYC` system cycles. `HALF_CYC` is chosen per system clock so that the serial timing limits hold: a period of at least 100 ns, each half at least 50 ns, and at least 50 ns of data and enable setup before a rising edge. At 250 MHz the default of 13 gives 52 ns halves. The clear pulse lasts `CLR_CYC` cycles, and the default of 50 gives 200 ns. Data changes only on the falling serial-clock edge, so it is stable at the rising edge where the converters capture it.

The controller has seven states:

- `ST_IDLE` collects words.
  - It moves to `ST_CLEAR` on a clear request.
  - Otherwise, once `N_DEV` words are held, it moves to `ST_LOW`.
- `ST_LOW` is the clock-low half with a bit presented. It moves to `ST_HIGH` when its phase ends.
- `ST_HIGH` is the clock-high half. When its phase ends it returns to `ST_LOW` with the next bit, or goes to `ST_ARM` after the last bit.
- `ST_ARM` is clock low with the update enable low and the shift enable high. It moves to `ST_STROBE`.
- `ST_STROBE` is the single clock-high pulse that loads every output latch. It moves to `ST_DONE`.
- `ST_DONE` lasts one cycle and returns to `ST_IDLE`.
- `ST_CLEAR` holds the clear line low and returns to `ST_IDLE` when its phase ends.

Top module: `dac_chain_loader`

## Requirements
- R1: After reset, dac_sclk is 0, dac_shift_n, dac_update_n and dac_clr_n are 1, done is 0 and in_ready is 1.
- R2: In idle, in_ready is 1 while fewer than N_DEV words are held. A word is taken in each cycle with in_valid and in_ready both high. in_ready drops in the cycle after the N_DEV-th word is taken and stays 0 until the cycle after done.
- R3: The cycle after the N_DEV-th word is taken, the block stays idle. In the cycle after that, dac_shift_n falls. It stays low for the whole burst, which contains exactly 16*N_DEV rising edges of dac_sclk.
- R4: The first word taken is shifted first and the last word taken is shifted last, each most significant bit first. The serial stream is therefore the words concatenated in acceptance order.
- R5: During a burst, dac_sdata changes only in the cycle where dac_sclk goes low, or when the burst starts. It never changes while dac_sclk is high.
- R6: In a burst, every high and every low phase of dac_sclk lasts exactly HALF_CYC cycles, counted from the fall of dac_shift_n. The burst lasts 2*16*N_DEV*HALF_CYC + 2*HALF_CYC + 1 cycles, from the fall of dac_shift_n up to and including the done cycle.
- R7: After the last data bit, these steps happen in order:
  - dac_shift_n rises and dac_update_n falls in the same cycle, with dac_sclk low.
  - One dac_sclk high pulse follows while dac_update_n is low.
  - dac_update_n rises in the same cycle that dac_sclk falls.
  - The two enables are never low together.
- R8: done is high for exactly one cycle, the cycle in which dac_update_n returns high. in_ready is 1 again in the next cycle.
- R9: A clear request sampled in idle drives dac_clr_n low from the next cycle for exactly CLR_CYC cycles. During that time in_ready is 0 and the other chain lines are inactive. The request wins over starting a burst when all words are already held; that burst starts after the clear.
- R10: A clear request while dac_shift_n is low is ignored, and dac_clr_n stays high.
- R11: Words taken before a clear are kept, and the burst that follows includes them.
- R12: dac_sclk stays low whenever dac_shift_n and dac_update_n are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A word is offered on in_data |
| in_data | input | WORD_W | Code for the next converter, farthest first |
| in_ready | output | 1 | The block can take a word this cycle |
| clr_req | input | 1 | Request a clear pulse on the chain |
| dac_sclk | output | 1 | Shared serial clock |
| dac_sdata | output | 1 | Serial data into the first converter |
| dac_shift_n | output | 1 | Active-low shift-register enable |
| dac_update_n | output | 1 | Active-low output-latch enable |
| dac_clr_n | output | 1 | Active-low clear for the chain |
| done | output | 1 | One-cycle pulse after the update strobe |

## Verification
The bench builds the block with N_DEV = 3, HALF_CYC = 3 and CLR_CYC = 7. Three words make a 48-bit stream, so word order, a word boundary falling inside the stream, and both ends of the stream can all be observed in one burst. The odd phase and clear lengths expose off-by-one errors in the timer that even values could hide. The short phases also keep each burst near 300 cycles, so many random bursts, clears held across partial loads, clears that collide with a full buffer, and clears requested mid-burst all fit in one short run.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

    // Controller states of the chain loader.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOW    = 3'd1,
        ST_HIGH   = 3'd2,
        ST_ARM    = 3'd3,
        ST_STROBE = 3'd4,
        ST_DONE   = 3'd5,
        ST_CLEAR  = 3'd6
    } dcl_state_e;

    // True for the states that hold the serial clock high.
    function automatic logic clk_high(input dcl_state_e s);
        return (s == ST_HIGH) || (s == ST_STROBE);
    endfunction

endpackage

// File: rtl/dcl_phase_timer.sv
module dcl_phase_timer #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Loaded with length-1 on each state change, then counts down to zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= reload;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dcl_word_shifter.sv
module dcl_word_shifter #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned N_DEV  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              advance,
    output logic              ser_bit
);

    // One slot per converter.
    // A push moves every word one slot up, so the first word taken ends in
    // the top slot. An advance moves the whole chain left by one bit, with
    // each slot feeding its MSB into the slot above.
    genvar g;
    generate
        for (g = 0; g < N_DEV; g++) begin : g_slot
            logic [WORD_W-1:0] word_q;
            logic [WORD_W-1:0] fill_src;
            logic              carry_in;

            if (g == 0) begin : g_head
                assign fill_src = push_word;
                assign carry_in = 1'b0;
            end else begin : g_tail
                assign fill_src = g_slot[g-1].word_q;
                assign carry_in = g_slot[g-1].word_q[WORD_W-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (push) begin
                    word_q <= fill_src;
                end else if (advance) begin
                    word_q <= {word_q[WORD_W-2:0], carry_in};
                end
            end
        end
    endgenerate

    assign ser_bit = g_slot[N_DEV-1].word_q[WORD_W-1];

endmodule

// File: rtl/dcl_fsm.sv
module dcl_fsm
    import dcl_pkg::*;
#(
    parameter int unsigned N_DEV    = 3,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned HALF_CYC = 13,
    parameter int unsigned CLR_CYC  = 50,
    parameter int unsigned CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             clr_req,
    input  logic             phase_end,
    output logic             in_ready,
    output logic             push,
    output logic             advance,
    output logic             timer_restart,
    output logic [CNT_W-1:0] timer_reload,
    output logic             sclk,
    output logic             shift_n,
    output logic             update_n,
    output logic             clr_n,
    output logic             done
);

    localparam int unsigned TOTAL_BITS = N_DEV * WORD_W;
    localparam int unsigned BIT_W      = $clog2(TOTAL_BITS);
    localparam int unsigned WCNT_W     = $clog2(N_DEV + 1);

    dcl_state_e        state_q, state_d;
    logic [WCNT_W-1:0] word_cnt_q;
    logic [BIT_W-1:0]  bit_cnt_q;
    logic              full;
    logic              last_bit;

    assign full     = (word_cnt_q == WCNT_W'(N_DEV));
    assign last_bit = (bit_cnt_q == BIT_W'(TOTAL_BITS - 1));
    assign in_ready = (state_q == ST_IDLE) && !full;
    assign push     = in_valid && in_ready;
    assign advance  = (state_q == ST_HIGH) && phase_end && !last_bit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clr_req) begin
                    state_d = ST_CLEAR;
                end else if (full) begin
                    state_d = ST_LOW;
                end
            end
            ST_LOW:    if (phase_end) state_d = ST_HIGH;
            ST_HIGH:   if (phase_end) state_d = last_bit ? ST_ARM : ST_LOW;
            ST_ARM:    if (phase_end) state_d = ST_STROBE;
            ST_STROBE: if (phase_end) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_CLEAR:  if (phase_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Every state change starts a fresh phase; only the clear has its own length.
    assign timer_restart = (state_d != state_q);
    assign timer_reload  = (state_d == ST_CLEAR) ? CNT_W'(CLR_CYC - 1)
                                                 : CNT_W'(HALF_CYC - 1);

    // Words held; emptied once the update strobe has been issued.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_cnt_q <= '0;
        end else if (state_q == ST_DONE) begin
            word_cnt_q <= '0;
        end else if (push) begin
            word_cnt_q <= word_cnt_q + 1'b1;
        end
    end

    // Position in the burst; rewound while idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
        end else if (state_q == ST_IDLE) begin
            bit_cnt_q <= '0;
        end else if (advance) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // Chain lines registered from the next state, so the pins carry no decode glitches.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk     <= 1'b0;
            shift_n  <= 1'b1;
            update_n <= 1'b1;
            clr_n    <= 1'b1;
            done     <= 1'b0;
        end else begin
            sclk     <= clk_high(state_d);
            shift_n  <= !((state_d == ST_LOW) || (state_d == ST_HIGH));
            update_n <= !((state_d == ST_ARM) || (state_d == ST_STROBE));
            clr_n    <= (state_d != ST_CLEAR);
            done     <= (state_d == ST_DONE);
        end
    end

endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader #(
    parameter int unsigned N_DEV    = 3,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned HALF_CYC = 13,
    parameter int unsigned CLR_CYC  = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              clr_req,
    output logic              dac_sclk,
    output logic              dac_sdata,
    output logic              dac_shift_n,
    output logic              dac_update_n,
    output logic              dac_clr_n,
    output logic              done
);

    localparam int unsigned LONGEST = (HALF_CYC > CLR_CYC) ? HALF_CYC : CLR_CYC;
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

    logic             push;
    logic             advance;
    logic             timer_restart;
    logic [CNT_W-1:0] timer_reload;
    logic             phase_end;

    dcl_fsm #(
        .N_DEV    (N_DEV),
        .WORD_W   (WORD_W),
        .HALF_CYC (HALF_CYC),
        .CLR_CYC  (CLR_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .clr_req       (clr_req),
        .phase_end     (phase_end),
        .in_ready      (in_ready),
        .push          (push),
        .advance       (advance),
        .timer_restart (timer_restart),
        .timer_reload  (timer_reload),
        .sclk          (dac_sclk),
        .shift_n       (dac_shift_n),
        .update_n      (dac_update_n),
        .clr_n         (dac_clr_n),
        .done          (done)
    );

    dcl_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .reload  (timer_reload),
        .expired (phase_end)
    );

    dcl_word_shifter #(
        .WORD_W (WORD_W),
        .N_DEV  (N_DEV)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (in_data),
        .advance   (advance),
        .ser_bit   (dac_sdata)
    );

endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
    parameter int unsigned HALF_CYC = 13
) (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic clr_req,
    input logic sclk,
    input logic sdata,
    input logic shift_n,
    input logic update_n,
    input logic clr_n,
    input logic done
);

    logic        sclk_q;
    logic        shift_q;
    logic [15:0] run_q;

    // Length of the current serial-clock level, restarted at each edge and at burst start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            shift_q <= 1'b1;
            run_q   <= '0;
        end else begin
            sclk_q  <= sclk;
            shift_q <= shift_n;
            if ((sclk != sclk_q) || (shift_q && !shift_n)) begin
                run_q <= 16'd1;
            end else if (run_q != 16'hFFFF) begin
                run_q <= run_q + 16'd1;
            end
        end
    end

    assert_phase_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != sclk_q) |-> (run_q == 16'(HALF_CYC)));

    assert_hold_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_n |-> !in_ready);

    assert_sdata_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_n && sclk) |-> $stable(sdata));

    assert_enables_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !update_n |-> shift_n);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (update_n && $past(!update_n)));

    assert_clear_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (shift_n && update_n && !sclk && !in_ready));

    assert_clear_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !shift_n) |=> clr_n);

    assert_sclk_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_n && update_n) |-> !sclk);

endmodule

bind dac_chain_loader dcl_checker #(
    .HALF_CYC (HALF_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .clr_req  (clr_req),
    .sclk     (dac_sclk),
    .sdata    (dac_sdata),
    .shift_n  (dac_shift_n),
    .update_n (dac_update_n),
    .clr_n    (dac_clr_n),
    .done     (done)
);

// File: tb/dac_chain_loader_tb.sv
`timescale 1ns/1ps
module dac_chain_loader_tb;

    localparam int TB_N    = 3;
    localparam int TB_W    = 16;
    localparam int TB_HALF = 3;
    localparam int TB_CLR  = 7;
    localparam int TOT     = TB_N * TB_W;
    localparam int BURST_LEN = 2 * TOT * TB_HALF + 2 * TB_HALF + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [TB_W-1:0] in_data = '0;
    logic            in_ready;
    logic            clr_req = 1'b0;
    logic            dac_sclk, dac_sdata, dac_shift_n, dac_update_n, dac_clr_n, done;

    int n_chk = 0;
    int n_bad = 0;

    logic [TB_W-1:0] wq [TB_N];

    always #2 clk = ~clk;

    dac_chain_loader #(
        .N_DEV    (TB_N),
        .WORD_W   (TB_W),
        .HALF_CYC (TB_HALF),
        .CLR_CYC  (TB_CLR)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .clr_req      (clr_req),
        .dac_sclk     (dac_sclk),
        .dac_sdata    (dac_sdata),
        .dac_shift_n  (dac_shift_n),
        .dac_update_n (dac_update_n),
        .dac_clr_n    (dac_clr_n),
        .done         (done)
    );

    // ---------------- pin monitor ----------------
    logic           active = 1'b0;
    logic [TOT-1:0] stream = '0;
    int rise_cnt = 0, strobe_cnt = 0, phase_len = 0, burst_len = 0;
    int viol_phase = 0, viol_sdo = 0, viol_seq = 0, viol_clr = 0;
    int stray_rise = 0, double_done = 0;
    logic pv_sclk = 1'b0, pv_shift = 1'b1, pv_upd = 1'b1, pv_sdo = 1'b0, pv_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pv_shift && !dac_shift_n) begin
                active = 1'b1;
                stream = '0;
                rise_cnt = 0; strobe_cnt = 0; phase_len = 1; burst_len = 1;
                viol_phase = 0; viol_sdo = 0; viol_seq = 0; viol_clr = 0;
            end else if (active) begin
                burst_len++;
                if (dac_sclk != pv_sclk) begin
                    if (phase_len != TB_HALF) viol_phase++;
                    phase_len = 1;
                end else begin
                    phase_len++;
                end
                if (dac_sclk && !pv_sclk) begin
                    if (!dac_shift_n) begin
                        stream = {stream[TOT-2:0], dac_sdata};
                        rise_cnt++;
                    end else if (!dac_update_n) begin
                        strobe_cnt++;
                    end
                end
                if (!dac_shift_n && dac_sclk && (dac_sdata != pv_sdo)) viol_sdo++;
                if (dac_shift_n && !pv_shift) begin
                    if (!(!dac_update_n && pv_upd) || dac_sclk || rise_cnt != TOT) viol_seq++;
                end
                if (dac_update_n && !pv_upd && (dac_sclk || !done)) viol_seq++;
                if (!dac_clr_n) viol_clr++;
                if (done) active = 1'b0;
            end
            if (dac_sclk && !pv_sclk && dac_shift_n && dac_update_n) stray_rise++;
            if (done && pv_done) double_done++;
            pv_sclk = dac_sclk; pv_shift = dac_shift_n; pv_upd = dac_update_n;
            pv_sdo = dac_sdata; pv_done = done;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [TOT-1:0] exp_stream();
        logic [TOT-1:0] s = '0;
        for (int i = 0; i < TB_N; i++) s = (s << TB_W) | TOT'(wq[i]);
        return s;
    endfunction

    task automatic send_word(input logic [TB_W-1:0] w, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Called at the negedge right after the last word was taken.
    task automatic start_checks();
        check(in_ready == 1'b0, "R2 ready drops when full", 64'(in_ready), 64'd0);
        check(dac_shift_n == 1'b1, "R3 idle cycle before burst", 64'(dac_shift_n), 64'd1);
        @(negedge clk);
        check(dac_shift_n == 1'b0, "R3 burst starts", 64'(dac_shift_n), 64'd0);
    endtask

    task automatic finish_checks(input bit mid_clr, input string tag);
        int t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
            if (mid_clr && t == 20) clr_req = 1'b1;
            if (mid_clr && t == 21) clr_req = 1'b0;
        end
        check(done == 1'b1, {tag, " R8 done reached"}, 64'(done), 64'd1);
        @(negedge clk);
        check(done == 1'b0, {tag, " R8 done one cycle"}, 64'(done), 64'd0);
        check(in_ready == 1'b1, {tag, " R8 ready back"}, 64'(in_ready), 64'd1);
        check(stream == exp_stream(), {tag, " R4 stream order"}, 64'(stream), 64'(exp_stream()));
        check(rise_cnt == TOT, {tag, " R3 rise count"}, 64'(rise_cnt), 64'(TOT));
        check(viol_phase == 0, {tag, " R6 phase length"}, 64'(viol_phase), 64'd0);
        check(burst_len == BURST_LEN, {tag, " R6 burst length"}, 64'(burst_len), 64'(BURST_LEN));
        check(viol_sdo == 0, {tag, " R5 data stable at high"}, 64'(viol_sdo), 64'd0);
        check(strobe_cnt == 1 && viol_seq == 0, {tag, " R7 strobe sequence"},
              64'(viol_seq), 64'd0);
        check(viol_clr == 0, {tag, " R10 no clear in burst"}, 64'(viol_clr), 64'd0);
    endtask

    task automatic clear_pulse(input string tag);
        int len = 0;
        @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        check(dac_clr_n == 1'b0, {tag, " R9 clear starts"}, 64'(dac_clr_n), 64'd0);
        while (!dac_clr_n && len < 1000) begin
            if (in_ready || !dac_shift_n || !dac_update_n || dac_sclk) begin
                check(1'b0, {tag, " R9 quiet during clear"}, 64'(in_ready), 64'd0);
            end
            len++;
            @(negedge clk);
        end
        check(len == TB_CLR, {tag, " R9 clear length"}, 64'(len), 64'(TB_CLR));
    endtask

    task automatic burst(input bit mid_clr, input string tag);
        for (int i = 0; i < TB_N; i++) send_word(wq[i], int'($urandom_range(0, 3)));
        start_checks();
        finish_checks(mid_clr, tag);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_sclk == 1'b0 && dac_shift_n && dac_update_n && dac_clr_n,
              "R1 reset chain lines", {60'd0, dac_sclk, dac_shift_n, dac_update_n, dac_clr_n}, 64'h7);
        check(done == 1'b0 && in_ready == 1'b1, "R1 reset handshake",
              {62'd0, done, in_ready}, 64'h1);

        // Directed: sign-bit and LSB corner codes expose order and bit direction.
        wq[0] = 16'h8000; wq[1] = 16'h7FFF; wq[2] = 16'h0001;
        burst(1'b0, "dir0");
        wq[0] = 16'hFFFF; wq[1] = 16'h0000; wq[2] = 16'hA5C3;
        burst(1'b0, "dir1");

        // Random bursts.
        for (int b = 0; b < 6; b++) begin
            for (int i = 0; i < TB_N; i++) wq[i] = 16'($urandom);
            burst(1'b0, "rand");
        end

        // R9: clear from an empty idle.
        clear_pulse("idle");

        // R11: one word held across a clear.
        for (int i = 0; i < TB_N; i++) wq[i] = 16'($urandom);
        send_word(wq[0], 1);
        clear_pulse("R11 partial");
        for (int i = 1; i < TB_N; i++) send_word(wq[i], 0);
        start_checks();
        finish_checks(1'b0, "R11 kept words");

        // R9 priority: clear requested in the cycle the buffer is full.
        for (int i = 0; i < TB_N; i++) wq[i] = 16'($urandom);
        for (int i = 0; i < TB_N; i++) send_word(wq[i], 0);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        check(dac_clr_n == 1'b0 && dac_shift_n == 1'b1, "R9 clear wins over start",
              {62'd0, dac_clr_n, dac_shift_n}, 64'h1);
        while (!dac_clr_n) @(negedge clk);
        check(dac_shift_n == 1'b1, "R9 idle after clear", 64'(dac_shift_n), 64'd1);
        @(negedge clk);
        check(dac_shift_n == 1'b0, "R9 burst after clear", 64'(dac_shift_n), 64'd0);
        finish_checks(1'b0, "R9 post clear");

        // R10: clear request in mid-burst has no effect.
        for (int i = 0; i < TB_N; i++) wq[i] = 16'($urandom);
        burst(1'b1, "R10 mid clear");

        repeat (5) @(negedge clk);
        check(stray_rise == 0, "R12 no stray serial clock", 64'(stray_rise), 64'd0);
        check(double_done == 0, "R8 done never doubled", 64'(double_done), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule